// File: doc/BRIEF.md
# Flash Word-Program Sequencer

This block sits on the host side of a parallel NOR flash device and turns a single word-program request into the full bus conversation the device expects. A host asserts a request with a word address and a data word. The sequencer writes the three unlock/setup cycles and then the target cycle, back to back. It then reads status from the programmed address until the device's embedded algorithm reports completion or a timeout. Once the operation ends, it pulses an acknowledge that carries a fail indication.

The device signals completion in one of two ways, and a parameter picks which one the sequencer watches. In the default mode the poll bit reads back the complement of data bit 7 until the word is written. In the alternative mode bit 6 toggles on every read while the device is busy. The device also has a timeout flag on bit 5. That flag changes in the same read as the completion bit, so seeing it set is never enough to declare failure: the sequencer always re-reads before deciding. After a failure, the sequencer writes the reset code so the device returns to array-read mode, and only then acknowledges. A request with an odd address is refused at once and never reaches the bus.

Top module: `flash_pgm_seq`

## Requirements
- R1: After reset `busy`, `ack`, `fail` and `bus_req` are all 0.
- R2: An accepted even-address request produces exactly four bus writes, in this order: (UNLOCK_A, 0xAA), (UNLOCK_B, 0x55), (UNLOCK_A, 0xA0), (target address, data word). Each bus transfer holds `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` steady until `bus_ack`.
- R3: A request whose address bit 0 is 1 is acknowledged with `fail`=1 on the cycle after acceptance, and no bus transfer is made.
- R4: Every status read uses the target address of the current request.
- R5: In bit-7 mode (TOGGLE_MODE=0), a status read whose bit 7 equals bit 7 of the data word ends the request with `ack`=1 and `fail`=0.
- R6: In bit-7 mode, a read with bit 7 mismatching and bit 5 = 1 causes exactly one more read. If bit 7 matches in that read, the request passes.
- R7: If that extra read still mismatches, the sequencer writes RESET_CODE (0xF0) to the target address and then acknowledges with `fail`=1. A word that would need any bit to go from 0 to 1 ends on this path.
- R8: While `busy` is 1, changes on `req`, `req_addr` and `req_data` have no effect on the transfer in progress. `busy` stays 1 from acceptance up to and including the `ack` cycle.
- R9: In toggle mode (TOGGLE_MODE=1), two consecutive status reads with equal bit 6 end the request with a pass.
- R10: In toggle mode, a read with bit 6 differing from the previous read and bit 5 = 1 starts two fresh reads. The request passes if their bit 6 values are equal. Otherwise it fails through the R7 reset write.
- R11: `ack` is high for exactly one cycle per request, and `fail` is 0 whenever `ack` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Program request, sampled while idle |
| req_addr | input | AW | Word target address (bit 0 must be 0) |
| req_data | input | DW | Data word to program |
| busy | output | 1 | Request in progress |
| ack | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Failure indication, valid with ack |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Transfer is a write |
| bus_addr | output | AW | Transfer address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with bus_ack |
| bus_ack | input | 1 | Transfer completion from the device side |

## Verification
The bench instantiates the block twice with AW=12 and DW=16: once with TOGGLE_MODE=0 and once with TOGGLE_MODE=1. Each instance drives its own behavioural flash model, so both completion-detection variants and their re-read rules can be exercised. The model's busy-read count can be set, and it can force the timeout flag with or without a later recovery. This lets the bench reach the pass-after-timeout case, the genuine-failure case and the 0-to-1 programming failure in both modes.

// File: rtl/flash_pgm_pkg.sv
// Shared types for the flash program sequencer.
// Assumes status bits sit at positions 7 (data poll), 6 (toggle), 5 (timeout).
package flash_pgm_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_POLL, S_RECHK, S_RST, S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        V_WAIT, V_PASS, V_FAIL, V_RECHK
    } verdict_t;

    localparam int BIT_POLL    = 7;
    localparam int BIT_TOGGLE  = 6;
    localparam int BIT_TIMEOUT = 5;
endpackage

// File: rtl/flash_cmd_gen.sv
// Command cycle generator: maps the cycle index (0..3) of a word-program
// sequence to the bus address and data. Index 3 carries the target.
// Assumes DW >= 8; unlock codes fill the low byte.
module flash_cmd_gen #(
    parameter int AW = 12,
    parameter int DW = 16,
    parameter logic [AW-1:0] UNLOCK_A = 'hAAA,
    parameter logic [AW-1:0] UNLOCK_B = 'h554
) (
    input  logic [1:0]    idx,
    input  logic [AW-1:0] tgt_addr,
    input  logic [DW-1:0] tgt_data,
    output logic [AW-1:0] cyc_addr,
    output logic [DW-1:0] cyc_data
);
    localparam logic [DW-1:0] CODE_UNLK1 = DW'(8'hAA);
    localparam logic [DW-1:0] CODE_UNLK2 = DW'(8'h55);
    localparam logic [DW-1:0] CODE_PROG  = DW'(8'hA0);

    // Select the address/data pair of the current cycle.
    always_comb begin
        unique case (idx)
            2'd0:    begin cyc_addr = UNLOCK_A; cyc_data = CODE_UNLK1; end
            2'd1:    begin cyc_addr = UNLOCK_B; cyc_data = CODE_UNLK2; end
            2'd2:    begin cyc_addr = UNLOCK_A; cyc_data = CODE_PROG;  end
            default: begin cyc_addr = tgt_addr; cyc_data = tgt_data;   end
        endcase
    end
endmodule

// File: rtl/flash_poll_eval.sv
// Status read evaluator: decides, from one read word and prior state,
// whether to keep polling, pass, fail or start the post-timeout re-read.
// TOGGLE_MODE=0 compares bit 7 with the data; 1 compares bit 6 between reads.
module flash_poll_eval
    import flash_pgm_pkg::*;
#(
    parameter int DW = 16,
    parameter bit TOGGLE_MODE = 1'b0
) (
    input  logic [DW-1:0] rd_word,
    input  logic          exp_bit7,
    input  logic          prev_tog,
    input  logic          have_prev,
    input  logic          in_rechk,
    output verdict_t      verdict
);
    logic done_now;

    generate
        if (TOGGLE_MODE) begin : g_tog
            // Toggle compare: done when bit 6 repeats; first read only primes.
            always_comb done_now = have_prev && (rd_word[BIT_TOGGLE] == prev_tog);
        end else begin : g_dq7
            // Data poll compare: done when bit 7 equals the written bit 7.
            always_comb done_now = (rd_word[BIT_POLL] == exp_bit7);
        end
    endgenerate

    // Map the comparison and the timeout flag onto a verdict.
    always_comb begin
        if (TOGGLE_MODE && !have_prev)
            verdict = V_WAIT;
        else if (done_now)
            verdict = V_PASS;
        else if (in_rechk)
            verdict = V_FAIL;
        else if (rd_word[BIT_TIMEOUT])
            verdict = V_RECHK;
        else
            verdict = V_WAIT;
    end
endmodule

// File: rtl/flash_pgm_seq.sv
// Word-program sequencer: accepts one request, writes the four program
// cycles, polls status at the target address, re-reads after a timeout
// flag, writes the reset code on failure and pulses ack with fail.
// Assumes the device holds bus_ack for one cycle per transfer.
module flash_pgm_seq
    import flash_pgm_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16,
    parameter bit TOGGLE_MODE = 1'b0,
    parameter logic [AW-1:0] UNLOCK_A = 'hAAA,
    parameter logic [AW-1:0] UNLOCK_B = 'h554,
    parameter logic [DW-1:0] RESET_CODE = 'hF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          busy,
    output logic          ack,
    output logic          fail,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack
);
    seq_state_t    state;
    logic [1:0]    idx;
    logic [AW-1:0] tgt_addr;
    logic [DW-1:0] tgt_data;
    logic          fail_q;
    logic          prev_tog;
    logic          have_prev;
    logic [AW-1:0] cyc_addr;
    logic [DW-1:0] cyc_data;
    verdict_t      verdict;

    flash_cmd_gen #(
        .AW(AW), .DW(DW), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)
    ) u_cmd (
        .idx(idx), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
        .cyc_addr(cyc_addr), .cyc_data(cyc_data)
    );

    flash_poll_eval #(.DW(DW), .TOGGLE_MODE(TOGGLE_MODE)) u_eval (
        .rd_word(bus_rdata), .exp_bit7(tgt_data[BIT_POLL]),
        .prev_tog(prev_tog), .have_prev(have_prev),
        .in_rechk(state == S_RECHK), .verdict(verdict)
    );

    // Main sequencing: request capture, command cycles, polling, reset write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            idx       <= '0;
            tgt_addr  <= '0;
            tgt_data  <= '0;
            fail_q    <= 1'b0;
            prev_tog  <= 1'b0;
            have_prev <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (req) begin
                    tgt_addr  <= req_addr;
                    tgt_data  <= req_data;
                    fail_q    <= req_addr[0];
                    idx       <= '0;
                    have_prev <= 1'b0;
                    state     <= req_addr[0] ? S_DONE : S_CMD;
                end
                S_CMD: if (bus_ack) begin
                    if (idx == 2'd3) state <= S_POLL;
                    idx <= idx + 2'd1;
                end
                S_POLL, S_RECHK: if (bus_ack) begin
                    prev_tog  <= bus_rdata[BIT_TOGGLE];
                    have_prev <= (verdict != V_RECHK);
                    unique case (verdict)
                        V_PASS:  begin fail_q <= 1'b0; state <= S_DONE; end
                        V_FAIL:  begin fail_q <= 1'b1; state <= S_RST;  end
                        V_RECHK: state <= S_RECHK;
                        default: state <= state;
                    endcase
                end
                S_RST:   if (bus_ack) state <= S_DONE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Host-side outputs decoded from the state.
    always_comb begin
        busy = (state != S_IDLE);
        ack  = (state == S_DONE);
        fail = ack && fail_q;
    end

    // Bus-side outputs: command cycle, status read or reset write.
    always_comb begin
        bus_req   = (state == S_CMD) || (state == S_POLL) ||
                    (state == S_RECHK) || (state == S_RST);
        bus_we    = (state == S_CMD) || (state == S_RST);
        bus_addr  = (state == S_CMD) ? cyc_addr : tgt_addr;
        bus_wdata = (state == S_CMD) ? cyc_data :
                    (state == S_RST) ? RESET_CODE : '0;
    end
endmodule

// File: rtl/flash_pgm_seq_chk.sv
// Protocol checker for flash_pgm_seq, observing ports only.
// Assumes a single outstanding request and a one-cycle device ack.
module flash_pgm_seq_chk #(
    parameter int AW = 12,
    parameter int DW = 16,
    parameter logic [DW-1:0] RESET_CODE = 'hF0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic [AW-1:0] req_addr,
    input logic          busy,
    input logic          ack,
    input logic          fail,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_ack
);
    logic [AW-1:0] cap_addr;
    logic          cap_odd;
    logic          saw_rst;

    // Track the accepted address and whether a reset write went out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_odd  <= 1'b0;
            saw_rst  <= 1'b0;
        end else begin
            if (req && !busy) begin
                cap_addr <= req_addr;
                cap_odd  <= req_addr[0];
                saw_rst  <= 1'b0;
            end else if (bus_req && bus_we && bus_ack && bus_wdata == RESET_CODE) begin
                saw_rst <= 1'b1;
            end
        end
    end

    a_r2_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    a_r3_odd_reject: assert property (@(posedge clk) disable iff (!rst_n)
        req && !busy && req_addr[0] |=> ack && fail && !bus_req);

    a_r4_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we |-> bus_addr == cap_addr);

    a_r7_reset_before_fail: assert property (@(posedge clk) disable iff (!rst_n)
        ack && fail && !cap_odd |-> saw_rst);

    a_r8_bus_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy);

    a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    a_r11_fail_qual: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> ack);
endmodule

bind flash_pgm_seq flash_pgm_seq_chk #(.AW(AW), .DW(DW), .RESET_CODE(RESET_CODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .busy(busy), .ack(ack), .fail(fail), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack)
);

// File: tb/flash_pgm_seq_tb.sv
`timescale 1ns/1ps
// Behavioural flash: unlock sequence, AND-programming, busy status reads,
// forced or natural timeout flag, optional recovery after the flag.
module flash_model #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          ack,
    input  logic [7:0]    cfg_busy_reads,
    input  logic          cfg_force_to,
    input  logic          cfg_recover
);
    logic [DW-1:0] mem [16];
    int wr_count, rd_count, rd_bad, seq_err, rst_count;
    logic [1:0]    cnt;
    logic          busy_m, fault, tog;
    logic [7:0]    left;
    logic [DW-1:0] pend;
    logic [AW-1:0] paddr;

    function automatic logic [DW-1:0] status(input logic b7, input logic b6, input logic b5);
        logic [DW-1:0] s;
        s = '0; s[7] = b7; s[6] = b6; s[5] = b5;
        return s;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= '1;
            ack <= 1'b0; rdata <= '0; cnt <= '0; busy_m <= 1'b0; fault <= 1'b0;
            tog <= 1'b0; left <= '0; pend <= '0; paddr <= '0;
            wr_count <= 0; rd_count <= 0; rd_bad <= 0; seq_err <= 0; rst_count <= 0;
        end else begin
            ack <= req && !ack;
            if (req && !ack && we) begin
                wr_count <= wr_count + 1;
                if (wdata == DW'(8'hF0)) begin
                    rst_count <= rst_count + 1; cnt <= '0; busy_m <= 1'b0; fault <= 1'b0;
                end else if (!busy_m) begin
                    case (cnt)
                        2'd0: if (addr == 'hAAA && wdata == DW'(8'hAA)) cnt <= 2'd1;
                              else seq_err <= seq_err + 1;
                        2'd1: if (addr == 'h554 && wdata == DW'(8'h55)) cnt <= 2'd2;
                              else begin seq_err <= seq_err + 1; cnt <= '0; end
                        2'd2: if (addr == 'hAAA && wdata == DW'(8'hA0)) cnt <= 2'd3;
                              else begin seq_err <= seq_err + 1; cnt <= '0; end
                        default: begin
                            mem[addr[4:1]] <= mem[addr[4:1]] & wdata;
                            pend   <= wdata;
                            paddr  <= addr;
                            fault  <= ((wdata & ~mem[addr[4:1]]) != '0) || cfg_force_to;
                            busy_m <= 1'b1;
                            left   <= cfg_busy_reads;
                            tog    <= 1'b0;
                            cnt    <= '0;
                        end
                    endcase
                end
            end else if (req && !ack) begin
                rd_count <= rd_count + 1;
                if (addr != paddr) rd_bad <= rd_bad + 1;
                if (!busy_m) begin
                    rdata <= mem[addr[4:1]];
                end else if (left != 0) begin
                    left <= left - 8'd1; tog <= ~tog;
                    rdata <= status(~pend[7], ~tog, 1'b0);
                end else if (fault) begin
                    tog <= ~tog;
                    rdata <= status(~pend[7], ~tog, 1'b1);
                    if (cfg_recover) begin busy_m <= 1'b0; fault <= 1'b0; end
                end else begin
                    busy_m <= 1'b0;
                    rdata <= mem[paddr[4:1]];
                end
            end
        end
    end
endmodule

module flash_pgm_seq_tb;
    localparam int AW = 12;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Instance 0: bit-7 polling
    logic req0 = 1'b0; logic [AW-1:0] ra0 = '0; logic [DW-1:0] rd0 = '0;
    logic busy0, ack0, fail0, breq0, bwe0, back0;
    logic [AW-1:0] baddr0; logic [DW-1:0] bwd0, brd0;
    logic [7:0] nb0 = 8'd3; logic fto0 = 1'b0; logic rec0 = 1'b0;
    // Instance 1: toggle polling
    logic req1 = 1'b0; logic [AW-1:0] ra1 = '0; logic [DW-1:0] rd1 = '0;
    logic busy1, ack1, fail1, breq1, bwe1, back1;
    logic [AW-1:0] baddr1; logic [DW-1:0] bwd1, brd1;
    logic [7:0] nb1 = 8'd3; logic fto1 = 1'b0; logic rec1 = 1'b0;

    flash_pgm_seq #(.AW(AW), .DW(DW), .TOGGLE_MODE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req0), .req_addr(ra0), .req_data(rd0),
        .busy(busy0), .ack(ack0), .fail(fail0), .bus_req(breq0), .bus_we(bwe0),
        .bus_addr(baddr0), .bus_wdata(bwd0), .bus_rdata(brd0), .bus_ack(back0));
    flash_model #(.AW(AW), .DW(DW)) u_fl0 (
        .clk(clk), .rst_n(rst_n), .req(breq0), .we(bwe0), .addr(baddr0), .wdata(bwd0),
        .rdata(brd0), .ack(back0), .cfg_busy_reads(nb0), .cfg_force_to(fto0), .cfg_recover(rec0));

    flash_pgm_seq #(.AW(AW), .DW(DW), .TOGGLE_MODE(1'b1)) u_dut_tgl (
        .clk(clk), .rst_n(rst_n), .req(req1), .req_addr(ra1), .req_data(rd1),
        .busy(busy1), .ack(ack1), .fail(fail1), .bus_req(breq1), .bus_we(bwe1),
        .bus_addr(baddr1), .bus_wdata(bwd1), .bus_rdata(brd1), .bus_ack(back1));
    flash_model #(.AW(AW), .DW(DW)) u_fl1 (
        .clk(clk), .rst_n(rst_n), .req(breq1), .we(bwe1), .addr(baddr1), .wdata(bwd1),
        .rdata(brd1), .ack(back1), .cfg_busy_reads(nb1), .cfg_force_to(fto1), .cfg_recover(rec1));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Issue one request to an instance; returns fail and cycles to ack.
    task automatic run(input bit sel, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit scramble, output bit f, output int cyc);
        bit got = 0;
        bit busy_gap = 0;
        cyc = 0; f = 0;
        @(negedge clk);
        if (sel) begin req1 = 1; ra1 = a; rd1 = d; end
        else     begin req0 = 1; ra0 = a; rd0 = d; end
        while (!got && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (scramble && cyc == 3) begin
                if (sel) begin ra1 = a ^ 12'h00C; rd1 = ~d; end
                else     begin ra0 = a ^ 12'h00C; rd0 = ~d; end
            end
            if ((sel ? busy1 : busy0) == 1'b0) busy_gap = 1;
            if (sel ? ack1 : ack0) begin
                got = 1; f = sel ? fail1 : fail0;
                if (sel) req1 = 0; else req0 = 0;
            end
        end
        if (!got) begin
            chk(0, "watchdog", cyc, 0);
            if (sel) req1 = 0; else req0 = 0;
        end
        chk(!busy_gap, "R8 busy held to ack", busy_gap, 0);
        @(negedge clk);
        chk((sel ? ack1 : ack0) == 1'b0, "R11 ack single cycle", sel ? ack1 : ack0, 0);
        chk((sel ? fail1 : fail0) == 1'b0, "R11 fail only with ack", sel ? fail1 : fail0, 0);
    endtask

    task automatic t_reset();
        chk(!busy0 && !ack0 && !fail0 && !breq0, "R1 reset idle inst0", {busy0, ack0, fail0, breq0}, 0);
        chk(!busy1 && !ack1 && !fail1 && !breq1, "R1 reset idle inst1", {busy1, ack1, fail1, breq1}, 0);
    endtask

    task automatic t_prog_pass();
        bit f; int c; int w;
        w = u_fl0.wr_count;
        run(0, 12'h002, 16'h1234, 0, f, c);
        chk(!f, "R5 pass on bit7 match", f, 0);
        chk(u_fl0.wr_count - w == 4, "R2 four writes", u_fl0.wr_count - w, 4);
        chk(u_fl0.seq_err == 0, "R2 cycle order", u_fl0.seq_err, 0);
        chk(u_fl0.mem[1] == 16'h1234, "R2 word programmed", u_fl0.mem[1], 16'h1234);
        chk(u_fl0.rd_bad == 0, "R4 reads at target", u_fl0.rd_bad, 0);
    endtask

    task automatic t_odd();
        bit f; int c; int w; int r;
        w = u_fl0.wr_count; r = u_fl0.rd_count;
        run(0, 12'h005, 16'h0F0F, 0, f, c);
        chk(f, "R3 odd rejected", f, 1);
        chk(c == 1, "R3 ack next cycle", c, 1);
        chk(u_fl0.wr_count == w && u_fl0.rd_count == r, "R3 no bus traffic",
            u_fl0.wr_count - w + u_fl0.rd_count - r, 0);
    endtask

    task automatic t_multi();
        bit f1; bit f2; int c; int w;
        w = u_fl0.wr_count;
        run(0, 12'h004, 16'hA5A5, 0, f1, c);
        run(0, 12'h006, 16'h5A5A, 0, f2, c);
        chk(!f1 && !f2, "R5 two words pass", {f1, f2}, 0);
        chk(u_fl0.wr_count - w == 8, "R2 full command per word", u_fl0.wr_count - w, 8);
        chk(u_fl0.mem[2] == 16'hA5A5 && u_fl0.mem[3] == 16'h5A5A, "R2 both words stored",
            u_fl0.mem[3], 16'h5A5A);
    endtask

    task automatic t_recover();
        bit f; int c; int rs; int rd;
        rs = u_fl0.rst_count; rd = u_fl0.rd_count;
        fto0 = 1; rec0 = 1;
        run(0, 12'h008, 16'h00C3, 0, f, c);
        fto0 = 0; rec0 = 0;
        chk(!f, "R6 pass after timeout re-read", f, 0);
        chk(u_fl0.rd_count - rd == 5, "R6 exactly one extra read", u_fl0.rd_count - rd, 5);
        chk(u_fl0.rst_count == rs, "R6 no reset write", u_fl0.rst_count - rs, 0);
    endtask

    task automatic t_fault();
        bit f; int c; int rs;
        rs = u_fl0.rst_count;
        run(0, 12'h002, 16'hFFFF, 0, f, c);
        chk(f, "R7 zero-to-one fails", f, 1);
        chk(u_fl0.rst_count - rs == 1, "R7 reset code written", u_fl0.rst_count - rs, 1);
        chk(u_fl0.busy_m == 1'b0, "R7 device back in read mode", u_fl0.busy_m, 0);
        chk(u_fl0.rd_bad == 0, "R4 reads at target on fail", u_fl0.rd_bad, 0);
    endtask

    task automatic t_busy_ignore();
        bit f; int c;
        run(0, 12'h00A, 16'h3C3C, 1, f, c);
        chk(!f, "R8 pass with changing inputs", f, 0);
        chk(u_fl0.mem[5] == 16'h3C3C, "R8 original word kept", u_fl0.mem[5], 16'h3C3C);
        chk(u_fl0.mem[3] == 16'h5A5A, "R8 other word untouched", u_fl0.mem[3], 16'h5A5A);
    endtask

    task automatic t_tgl_pass();
        bit f; int c;
        nb1 = 8'd4;
        run(1, 12'h002, 16'h8421, 0, f, c);
        chk(!f, "R9 toggle pass", f, 0);
        chk(u_fl1.mem[1] == 16'h8421, "R9 word stored", u_fl1.mem[1], 16'h8421);
        chk(u_fl1.seq_err == 0 && u_fl1.rd_bad == 0, "R9 bus clean", u_fl1.seq_err + u_fl1.rd_bad, 0);
    endtask

    task automatic t_tgl_fault();
        bit f; int c; int rs;
        rs = u_fl1.rst_count;
        run(1, 12'h002, 16'hFFFF, 0, f, c);
        chk(f, "R10 toggle fail after timeout", f, 1);
        chk(u_fl1.rst_count - rs == 1, "R10 reset code written", u_fl1.rst_count - rs, 1);
    endtask

    task automatic t_tgl_recover();
        bit f; int c; int rs;
        rs = u_fl1.rst_count;
        fto1 = 1; rec1 = 1; nb1 = 8'd2;
        run(1, 12'h00C, 16'h0077, 0, f, c);
        fto1 = 0; rec1 = 0;
        chk(!f, "R10 toggle pass after timeout", f, 0);
        chk(u_fl1.rst_count == rs, "R10 no reset write on pass", u_fl1.rst_count - rs, 0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_prog_pass();
        t_odd();
        t_multi();
        t_recover();
        t_fault();
        t_busy_ignore();
        t_tgl_pass();
        t_tgl_fault();
        t_tgl_recover();
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule